// File: doc/BRIEF.md
# Per-Lane Link Event Counter

This block gives one root port of a serial link a single statistics counter. Software writes one control word through a small register port. That word names an event code and a lane, and it carries two command fields: one starts or stops counting, the other zeroes the count. While counting is on, the block adds one to its counter in every cycle where the strobe for the chosen event on the chosen lane is high. Software reads the result back as a 32-bit value.

Event strobes arrive as two flat vectors, one per event group. The link-layer group covers acknowledge, flow-control update, nullified and duplicate packets. The transaction group covers request and completion types in each direction. Each vector holds one run of bits per lane. There is exactly one counter. It raises no interrupt, and when it reaches its maximum it stops there.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the count is 0, counting is off, and the control word reads 0 (event 0, lane 0, status 0).
- R2: A write to offset 0x8 with 3'b011 in bits 4:2 turns counting on. Bit 7 of the control word reads 1 while counting is on and 0 otherwise.
- R3: A write with 3'b001 in bits 4:2 turns counting off and keeps the value. Any other value in bits 4:2 leaves the on/off state unchanged.
- R4: A write with 2'b01 in bits 1:0 zeroes the counter. Other values in bits 1:0 do nothing. Bits 4:2 and 1:0 always read back as 0.
- R5: When a clear and a counted strobe fall in the same cycle, the count after that edge is 0.
- R6: While counting is on, the count rises by exactly one for each cycle in which the selected strobe is high at a clock edge. Strobes of other events and other lanes have no effect. Event group bits are laid out lane-major: bit lane*LINK_N+k of `link_evt` carries code 0x600+k, and bit lane*TXN_N+k of `txn_evt` carries code 0x700+k.
- R7: Supported codes are 0x600..0x600+LINK_N-1 (0x600..0x606 by default) and 0x700..0x700+TXN_N-1 (0x700..0x717 by default). Any other code in bits 27:16 never increments the counter.
- R8: A lane number in bits 11:8 at or above LANES never increments the counter.
- R9: Changing the event or lane selection does not alter the count.
- R10: The counter saturates at all ones (2^CNT_W-1) and does not wrap.
- R11: Offset 0xC reads the count, zero-extended to 32 bits. Offset 0x8 reads the event in bits 27:16, the lane in bits 11:8 and the status in bit 7. Other offsets read 0. Writes to any offset other than 0x8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| link_evt | input | LANES*LINK_N | Link-layer event strobes, lane-major |
| txn_evt | input | LANES*TXN_N | Transaction event strobes, lane-major |

## Verification
A control write takes effect at the clock edge that samples it. Strobes present at that same edge are still judged against the old selection and the old run state, so a new setting first governs the strobes of the following cycle. A strobe that is high before edge N appears in the count read at offset 0xC right after edge N. Reads are combinational, so the bench drives stimulus on the falling edge and samples rdata 1 ns later. Its reference model advances in step with each rising edge, in the same order: clear, then increment, then control update.

// File: rtl/lec_pkg.sv
package lec_pkg;
   localparam int unsigned CTL_OFS  = 32'h08;
   localparam int unsigned CNT_OFS  = 32'h0C;
   localparam int unsigned EV_LSB   = 16;
   localparam int unsigned EV_W     = 12;
   localparam int unsigned LANE_LSB = 8;
   localparam int unsigned LANE_W   = 4;
   localparam int unsigned STAT_BIT = 7;
   localparam int unsigned EN_LSB   = 2;
   localparam int unsigned EN_W     = 3;
   localparam int unsigned CLR_LSB  = 0;
   localparam int unsigned CLR_W    = 2;
   localparam logic [EN_W-1:0]  EN_START = 3'd3;
   localparam logic [EN_W-1:0]  EN_STOP  = 3'd1;
   localparam logic [CLR_W-1:0] CLR_GO   = 2'd1;
   localparam logic [EV_W-1:0]  LINK_BASE = 12'h600;
   localparam logic [EV_W-1:0]  TXN_BASE  = 12'h700;
endpackage

// File: rtl/lec_ctl.sv
module lec_ctl
   import lec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [EV_W-1:0]   ev_in,
   input  logic [LANE_W-1:0] lane_in,
   input  logic [EN_W-1:0]   en_cmd,
   input  logic [CLR_W-1:0]  clr_cmd,
   output logic [EV_W-1:0]   ev_q,
   output logic [LANE_W-1:0] lane_q,
   output logic              run_q,
   output logic              clr_go
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q   <= '0;
         lane_q <= '0;
         run_q  <= 1'b0;
      end else if (wr) begin
         ev_q   <= ev_in;
         lane_q <= lane_in;
         if (en_cmd == EN_START)
            run_q <= 1'b1;
         else if (en_cmd == EN_STOP)
            run_q <= 1'b0;
      end
   end

   assign clr_go = wr && (clr_cmd == CLR_GO);
endmodule

// File: rtl/lec_evsel.sv
module lec_evsel
   import lec_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LINK_N = 7,
   parameter int unsigned TXN_N  = 24
) (
   input  logic [EV_W-1:0]         ev,
   input  logic [LANE_W-1:0]       lane,
   input  logic [LANES*LINK_N-1:0] link_evt,
   input  logic [LANES*TXN_N-1:0]  txn_evt,
   output logic                    sel_ok,
   output logic                    hit
);
   localparam int unsigned LI_W    = (LINK_N > 1) ? $clog2(LINK_N) : 1;
   localparam int unsigned TI_W    = (TXN_N > 1) ? $clog2(TXN_N) : 1;
   localparam int unsigned LI_SPAN = 2 ** LI_W;
   localparam int unsigned TI_SPAN = 2 ** TI_W;
   localparam int unsigned LSPAN   = 2 ** LANE_W;

   logic            link_ok, txn_ok, lane_ok;
   logic [LI_W-1:0] link_idx;
   logic [TI_W-1:0] txn_idx;
   logic [LSPAN-1:0] lane_hit;

   assign link_ok  = (ev >= LINK_BASE) && (ev < LINK_BASE + EV_W'(LINK_N));
   assign txn_ok   = (ev >= TXN_BASE) && (ev < TXN_BASE + EV_W'(TXN_N));
   assign link_idx = ev[LI_W-1:0];
   assign txn_idx  = ev[TI_W-1:0];
   assign lane_ok  = {1'b0, lane} < (LANE_W+1)'(LANES);

   for (genvar l = 0; l < LSPAN; l++) begin : g_lane
      if (l < LANES) begin : g_live
         logic [LI_SPAN-1:0] lv;
         logic [TI_SPAN-1:0] tv;
         assign lv = LI_SPAN'(link_evt[l*LINK_N +: LINK_N]);
         assign tv = TI_SPAN'(txn_evt[l*TXN_N +: TXN_N]);
         assign lane_hit[l] = link_ok ? lv[link_idx] : (txn_ok ? tv[txn_idx] : 1'b0);
      end else begin : g_dead
         assign lane_hit[l] = 1'b0;
      end
   end

   assign sel_ok = lane_ok && (link_ok || txn_ok);
   assign hit    = sel_ok && lane_hit[lane];
endmodule

// File: rtl/lec_satcnt.sv
module lec_satcnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc && (count != '1))
         count <= count + 1'b1;
   end
endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
   import lec_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned LINK_N = 7,
   parameter int unsigned TXN_N  = 24,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [31:0]             wdata,
   output logic [31:0]             rdata,
   input  logic [LANES*LINK_N-1:0] link_evt,
   input  logic [LANES*TXN_N-1:0]  txn_evt
);
   if (LANES < 1 || LANES > 2 ** LANE_W) begin : g_bad_lanes
      $error("LANES must lie in 1..16");
   end
   if (LINK_N < 1 || LINK_N > 256 || TXN_N < 1 || TXN_N > 256) begin : g_bad_groups
      $error("event group sizes must lie in 1..256");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 1..32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   logic              wr_ctl, clr_go, run_q, sel_ok, hit;
   logic [EV_W-1:0]   ev_q;
   logic [LANE_W-1:0] lane_q;
   logic [CNT_W-1:0]  count_q;
   logic              unused_wbits;

   assign wr_ctl       = wr_en && (addr == ADDR_W'(CTL_OFS));
   assign unused_wbits = ^{wdata[31:EV_LSB+EV_W], wdata[EV_LSB-1:LANE_LSB+LANE_W],
                           wdata[LANE_LSB-1:EN_LSB+EN_W]};

   lec_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_ctl),
      .ev_in   (wdata[EV_LSB +: EV_W]),
      .lane_in (wdata[LANE_LSB +: LANE_W]),
      .en_cmd  (wdata[EN_LSB +: EN_W]),
      .clr_cmd (wdata[CLR_LSB +: CLR_W]),
      .ev_q    (ev_q),
      .lane_q  (lane_q),
      .run_q   (run_q),
      .clr_go  (clr_go)
   );

   lec_evsel #(.LANES(LANES), .LINK_N(LINK_N), .TXN_N(TXN_N)) u_sel (
      .ev       (ev_q),
      .lane     (lane_q),
      .link_evt (link_evt),
      .txn_evt  (txn_evt),
      .sel_ok   (sel_ok),
      .hit      (hit)
   );

   lec_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_go),
      .inc   (run_q && hit),
      .count (count_q)
   );

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CTL_OFS)) begin
         rdata[EV_LSB +: EV_W]     = ev_q;
         rdata[LANE_LSB +: LANE_W] = lane_q;
         rdata[STAT_BIT]           = run_q;
      end else if (addr == ADDR_W'(CNT_OFS)) begin
         rdata = 32'(count_q);
      end
   end
endmodule

// File: rtl/lec_chk.sv
module lec_chk
   import lec_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic [CNT_W-1:0]  count,
   input logic              run,
   input logic              sel_ok,
   input logic              hit
);
   logic clrw;
   assign clrw = wr_en && (addr == ADDR_W'(CTL_OFS)) && (wdata[CLR_LSB +: CLR_W] == CLR_GO);

   // R4: a clear command leaves zero behind
   a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clrw |=> (count == '0));
   // R10: all ones is sticky until cleared
   a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ((count == '1) && !clrw) |=> (count == '1));
   // R3: stopped counter holds
   a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clrw) |=> $stable(count));
   // R7 / R8: unsupported selection never counts
   a_r8_bad_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok && !clrw) |=> $stable(count));
   // R6: step of at most one
   a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      !clrw |=> ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))));
   // R6: a selected strobe while running is counted
   a_r6_counts_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hit && !clrw && (count != '1)) |=> (count == CNT_W'($past(count) + 1'b1)));
   // R2: status bit mirrors the run state
   a_r2_status: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(CTL_OFS)) |-> (rdata[STAT_BIT] == run));
endmodule

bind lane_evt_counter lec_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .count  (count_q),
   .run    (run_q),
   .sel_ok (sel_ok),
   .hit    (hit)
);

// File: tb/lane_evt_counter_test.sv
`timescale 1ns/1ps
module lane_evt_counter_test;
   localparam int L  = 4;
   localparam int LE = 7;
   localparam int TE = 24;
   localparam int NL = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0]  addr = 8'h08;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, nrdata;
   logic [L*LE-1:0]  link = '0;
   logic [L*TE-1:0]  txn = '0;
   logic [NL*LE-1:0] nlink = '0;
   logic [NL*TE-1:0] ntxn = '0;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] m_cnt;
   logic        m_run;
   logic [11:0] m_ev;
   logic [3:0]  m_lane;

   always #2.5 clk = ~clk;

   lane_evt_counter uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .link_evt(link), .txn_evt(txn));

   lane_evt_counter #(.LANES(NL), .CNT_W(4)) uut_sat (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(nrdata), .link_evt(nlink), .txn_evt(ntxn));

   function automatic bit m_hit(input logic [11:0] ev, input logic [3:0] ln,
                                input logic [L*LE-1:0] lk, input logic [L*TE-1:0] tx);
      if (int'(ln) >= L) return 1'b0;
      if (ev >= 12'h600 && ev < 12'h600 + LE) return lk[int'(ln)*LE + int'(ev - 12'h600)];
      if (ev >= 12'h700 && ev < 12'h700 + TE) return tx[int'(ln)*TE + int'(ev - 12'h700)];
      return 1'b0;
   endfunction

   function automatic logic [31:0] ctl_word(input logic [11:0] ev, input logic [3:0] ln,
                                            input logic [2:0] en, input logic [1:0] cl);
      return {4'b0, ev, 4'b0, ln, 3'b0, en, cl};
   endfunction

   function automatic logic [31:0] m_ctl();
      return {4'b0, m_ev, 4'b0, m_lane, m_run, 7'b0};
   endfunction

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // called at a falling edge; reads, then waits for the next falling edge
   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      chk(tag, rdata, exp);
      @(negedge clk);
   endtask

   task automatic cyc(input bit w, input logic [31:0] wd,
                      input logic [L*LE-1:0] lk, input logic [L*TE-1:0] tx);
      bit h;
      wr_en = w; addr = 8'h08; wdata = wd; link = lk; txn = tx;
      h = m_hit(m_ev, m_lane, lk, tx);
      if (w && wd[1:0] == 2'd1) m_cnt = 0;
      else if (m_run && h && m_cnt != 32'hFFFF_FFFF) m_cnt = m_cnt + 1;
      if (w) begin
         if (wd[4:2] == 3'd3) m_run = 1'b1;
         else if (wd[4:2] == 3'd1) m_run = 1'b0;
         m_ev = wd[27:16];
         m_lane = wd[11:8];
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; link = '0; txn = '0;
   endtask

   function automatic logic [L*LE-1:0] lbit(input int ln, input int k);
      logic [L*LE-1:0] v = '0;
      v[ln*LE + k] = 1'b1;
      return v;
   endfunction

   function automatic logic [L*TE-1:0] tbit(input int ln, input int k);
      logic [L*TE-1:0] v = '0;
      v[ln*TE + k] = 1'b1;
      return v;
   endfunction

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] lastw;
      void'($urandom(32'd20240611));
      m_cnt = 0; m_run = 0; m_ev = 0; m_lane = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 and R11 reset values
      rd("R1 ctl", 8'h08, 32'h0);
      rd("R1 cnt", 8'h0C, 32'h0);
      rd("R11 unmapped", 8'h10, 32'h0);

      // R2 / R4: select 0x602 lane 1, clear and start
      cyc(1, ctl_word(12'h602, 4'd1, 3'd3, 2'd1), '0, '0);
      rd("R2 R4 ctl readback", 8'h08, 32'h0602_0180);
      rd("R11 ctl model", 8'h08, m_ctl());

      // R6 five selected strobes
      repeat (5) cyc(0, 0, lbit(1, 2), '0);
      rd("R6 five hits", 8'h0C, 32'd5);
      // R6 other lane / other event ignored
      cyc(0, 0, lbit(0, 2), '0);
      cyc(0, 0, lbit(1, 3), '0);
      cyc(0, 0, '0, tbit(1, 2));
      rd("R6 neighbours ignored", 8'h0C, 32'd5);

      // R3 stop holds, other codes leave state
      cyc(1, ctl_word(12'h602, 4'd1, 3'd1, 2'd0), '0, '0);
      repeat (3) cyc(0, 0, lbit(1, 2), '0);
      rd("R3 stopped hold", 8'h0C, 32'd5);
      rd("R3 status off", 8'h08, 32'h0602_0100);
      cyc(1, ctl_word(12'h602, 4'd1, 3'd2, 2'd0), '0, '0);
      cyc(0, 0, lbit(1, 2), '0);
      rd("R3 code 2 no start", 8'h0C, 32'd5);
      cyc(1, ctl_word(12'h602, 4'd1, 3'd3, 2'd0), '0, '0);
      cyc(1, ctl_word(12'h602, 4'd1, 3'd7, 2'd0), '0, '0);
      cyc(0, 0, lbit(1, 2), '0);
      rd("R3 code 7 keeps run", 8'h0C, 32'd6);

      // R9 reselect keeps count, then counts new source
      cyc(1, ctl_word(12'h70B, 4'd3, 3'd0, 2'd0), '0, '0);
      rd("R9 count kept", 8'h0C, 32'd6);
      repeat (2) cyc(0, 0, '0, tbit(3, 11));
      rd("R6 txn group", 8'h0C, 32'd8);

      // R4 clear code 2 does nothing; R5 clear beats increment
      cyc(1, ctl_word(12'h70B, 4'd3, 3'd0, 2'd2), '0, '0);
      rd("R4 clear code 2", 8'h0C, 32'd8);
      cyc(1, ctl_word(12'h70B, 4'd3, 3'd0, 2'd1), '0, tbit(3, 11));
      rd("R5 clear priority", 8'h0C, 32'd0);

      // R7 unsupported codes
      cyc(1, ctl_word(12'h607, 4'd0, 3'd3, 2'd0), '0, '0);
      repeat (2) cyc(0, 0, '1, '1);
      cyc(1, ctl_word(12'h718, 4'd0, 3'd3, 2'd0), '0, '0);
      repeat (2) cyc(0, 0, '1, '1);
      cyc(1, ctl_word(12'h500, 4'd0, 3'd3, 2'd0), '0, '0);
      repeat (2) cyc(0, 0, '1, '1);
      rd("R7 bad codes", 8'h0C, 32'd0);
      cyc(1, ctl_word(12'h606, 4'd0, 3'd3, 2'd0), '0, '0);
      cyc(0, 0, lbit(0, 6), '0);
      cyc(1, ctl_word(12'h717, 4'd2, 3'd3, 2'd0), '0, '0);
      cyc(0, 0, '0, tbit(2, 23));
      rd("R7 top codes", 8'h0C, 32'd2);

      // R8 lanes beyond range
      cyc(1, ctl_word(12'h600, 4'd4, 3'd3, 2'd0), '0, '0);
      repeat (2) cyc(0, 0, '1, '1);
      cyc(1, ctl_word(12'h700, 4'd15, 3'd3, 2'd0), '0, '0);
      repeat (2) cyc(0, 0, '1, '1);
      rd("R8 bad lane", 8'h0C, 32'd2);

      // R11 write to count offset ignored
      wr_en = 1'b1; addr = 8'h0C; wdata = ctl_word(12'h601, 4'd1, 3'd1, 2'd1);
      @(posedge clk); @(negedge clk); wr_en = 1'b0;
      rd("R11 write 0xC count", 8'h0C, 32'd2);
      rd("R11 write 0xC ctl", 8'h08, m_ctl());

      // random phase, R6 against model
      for (int i = 0; i < 1500; i++) begin
         logic [L*LE-1:0] lk;
         logic [L*TE-1:0] tx;
         bit w;
         lk = L*LE'($urandom);
         tx = {$urandom, $urandom, $urandom};
         w  = ($urandom % 10) == 0;
         lastw = 0;
         if (w) begin
            logic [11:0] ev;
            logic [2:0]  en;
            case ($urandom % 3)
               0: ev = 12'h600 + 12'($urandom % 9);
               1: ev = 12'h700 + 12'($urandom % 26);
               default: ev = 12'($urandom);
            endcase
            en = (($urandom % 2) == 0) ? 3'd3 : 3'($urandom);
            lastw = ctl_word(ev, 4'($urandom % 6), en, 2'($urandom)) | ($urandom & 32'hF000_F060);
         end
         cyc(w, lastw, lk, tx);
         addr = 8'h0C; #1;
         chk("R6 random count", rdata, m_cnt);
         if ((i % 16) == 0) begin
            addr = 8'h08; #1;
            chk("R11 random ctl", rdata, m_ctl());
         end
      end

      // R10 saturation on the 4-bit instance
      cyc(1, ctl_word(12'h600, 4'd0, 3'd3, 2'd1), '0, '0);
      nlink = '1;
      repeat (20) cyc(0, 0, '0, '0);
      addr = 8'h0C; #1;
      chk("R10 saturate", nrdata, 32'd15);
      @(negedge clk);
      repeat (3) cyc(0, 0, '0, '0);
      addr = 8'h0C; #1;
      chk("R10 still max", nrdata, 32'd15);
      nlink = '0;
      @(negedge clk);
      cyc(1, ctl_word(12'h600, 4'd0, 3'd3, 2'd1), '0, '0);
      addr = 8'h0C; #1;
      chk("R10 clear after max", nrdata, 32'd0);
      chk("R1 main model end", rdata, m_cnt);

      summary();
   end
endmodule